// File: doc/BRIEF.md
# Free-Running 64-bit Counter with Compare Channel

This block holds a 64-bit up-counter that advances once per clock while its run bit is set, plus a single compare channel. Software reaches it through a flat 32-bit register port: a one-cycle write strobe with address and data, and a combinational read that returns the register selected by the read address. When the comparator is enabled, a full 64-bit match between the counter and the compare value sets a pending flag. The interrupt line is that flag gated by an enable bit.

Writes to the counter halves, the compare halves, the increment and the control word do not take effect at once. They pass through a fixed delay of `LAT` cycles, which stands in for the crossing into a slower timer clock. When a delayed write lands, it sets its own bit in one of two write-status words, so software can poll for completion and then clear the bit by writing a one to it. With auto-increment selected, every match adds the increment to the compare value. The channel then fires periodically without further writes.

Neither half of the counter is latched on a read. Software gets a coherent 64-bit value by reading the high half, then the low half, then the high half again, and retrying when the two high reads differ.

Top module: `gcount_cmp`

## Requirements
- R1: After reset every register reads zero, the counter does not advance, and `irq` is low.
- R2: While control bit 8 is set, the counter rises by exactly one per clock. While it is clear, the counter holds its value.
- R3: The low half reads at 0x100 and the high half at 0x104, both live. A carry out of the low half reaches the high half on the same edge, so a high/low/high read sequence with retry returns a coherent value.
- R4: Writes to 0x100, 0x104, 0x200 (compare low), 0x204 (compare high), 0x208 (increment) and 0x240 (control) change the register exactly `LAT`=3 clock edges after the edge that samples the write. Before that, the old value still reads back.
- R5: When a delayed write lands, it sets a status bit. In the word at 0x24C, bit 0 is set by compare low, bit 1 by compare high, bit 2 by the increment and bit 16 by control. In the word at 0x110, bit 0 is set by counter low and bit 1 by counter high.
- R6: Writing 1 to a bit of 0x24C or 0x110 clears it on the sampling edge. Writing 0 leaves it unchanged.
- R7: With control bit 0 set, a match on all 64 bits of counter and compare value sets the pending flag (bit 0 of 0x244) on the following edge. A match of the low half alone does not set it. With control bit 0 clear, no match occurs.
- R8: With control bit 1 set, each match adds the increment register to the compare value. With it clear, the compare value stays as written and only one event occurs.
- R9: `irq` is high exactly when the pending flag and bit 0 of 0x248 are both set. Writes to 0x248 act on the sampling edge.
- R10: Writing 1 to bit 0 of 0x244 clears the pending flag on the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 12 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Read register address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Compare interrupt |

## Verification
Compare events are driven in several ways. A one-shot compare checks that the event fires once and the compare value is left alone. A periodic compare checks that the increment is added on each match, using the counter and compare values read at each event. A match that needs a carry into the high half shows that the comparison is 64 bits wide. A compare with a matching low half but a different high half must stay silent. Further runs with the comparator disabled, and with the interrupt masked, tell apart a missing match from a missing gate. A counter load just below the 32-bit wrap makes the first high/low/high read disagree, which exercises the retry path. Latency checks sample each delayed register one edge before and on the edge it lands, so an off-by-one delay shows up.

// File: rtl/gcount_cmp.sv
module gcount_cmp #(
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int CW = 2 * DW;
  localparam logic [AW-1:0] A_CNT_LO = AW'('h100);
  localparam logic [AW-1:0] A_CNT_HI = AW'('h104);
  localparam logic [AW-1:0] A_CSTAT  = AW'('h110);
  localparam logic [AW-1:0] A_CMP_LO = AW'('h200);
  localparam logic [AW-1:0] A_CMP_HI = AW'('h204);
  localparam logic [AW-1:0] A_INC    = AW'('h208);
  localparam logic [AW-1:0] A_CTRL   = AW'('h240);
  localparam logic [AW-1:0] A_ISTAT  = AW'('h244);
  localparam logic [AW-1:0] A_IEN    = AW'('h248);
  localparam logic [AW-1:0] A_GSTAT  = AW'('h24C);
  localparam int B_CEN  = 0;
  localparam int B_AUTO = 1;
  localparam int B_RUN  = 8;
  localparam int S_CTRL = 16;
  localparam logic [DW-1:0] CTRL_MASK = (DW'(1) << B_RUN) | (DW'(1) << B_AUTO) | (DW'(1) << B_CEN);

  logic [LAT-1:0] pv;
  logic [AW-1:0]  pa [LAT];
  logic [DW-1:0]  pd [LAT];
  logic           ap_v;
  logic [AW-1:0]  ap_a;
  logic [DW-1:0]  ap_d;

  logic [CW-1:0] cnt, cnt_nxt;
  logic [CW-1:0] cmp, cmp_nxt;
  logic [DW-1:0] inc;
  logic [DW-1:0] ctrl;
  logic [DW-1:0] gstat;
  logic [1:0]    cstat;
  logic          pend;
  logic          ie;

  logic slow_wr;
  logic ld_clo, ld_chi, ld_mlo, ld_mhi, ld_inc, ld_ctl;
  logic cnt_ld, cmp_ld;
  logic run, cen, auto_inc, match;
  logic pend_clr;
  logic [DW-1:0] gset, gclr;
  logic [1:0]    cset, cclr;

  assign slow_wr = wr_en && (wr_addr inside {A_CNT_LO, A_CNT_HI, A_CMP_LO, A_CMP_HI, A_INC, A_CTRL});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0;
      for (int i = 0; i < LAT; i++) begin
        pa[i] <= '0;
        pd[i] <= '0;
      end
    end else begin
      pv[0] <= slow_wr;
      pa[0] <= wr_addr;
      pd[0] <= wr_data;
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1];
        pa[i] <= pa[i-1];
        pd[i] <= pd[i-1];
      end
    end
  end

  assign ap_v = pv[LAT-1];
  assign ap_a = pa[LAT-1];
  assign ap_d = pd[LAT-1];

  assign ld_clo = ap_v && (ap_a == A_CNT_LO);
  assign ld_chi = ap_v && (ap_a == A_CNT_HI);
  assign ld_mlo = ap_v && (ap_a == A_CMP_LO);
  assign ld_mhi = ap_v && (ap_a == A_CMP_HI);
  assign ld_inc = ap_v && (ap_a == A_INC);
  assign ld_ctl = ap_v && (ap_a == A_CTRL);
  assign cnt_ld = ld_clo || ld_chi;
  assign cmp_ld = ld_mlo || ld_mhi;

  assign run      = ctrl[B_RUN];
  assign cen      = ctrl[B_CEN];
  assign auto_inc = ctrl[B_AUTO];
  assign match    = cen && (cnt == cmp);

  always_comb begin
    cnt_nxt = (run && !cnt_ld) ? cnt + CW'(1) : cnt;
    if (ld_clo) cnt_nxt[DW-1:0]  = ap_d;
    if (ld_chi) cnt_nxt[CW-1:DW] = ap_d;
  end

  always_comb begin
    cmp_nxt = (match && auto_inc) ? cmp + {{(CW-DW){1'b0}}, inc} : cmp;
    if (ld_mlo) cmp_nxt[DW-1:0]  = ap_d;
    if (ld_mhi) cmp_nxt[CW-1:DW] = ap_d;
  end

  assign pend_clr = wr_en && (wr_addr == A_ISTAT) && wr_data[0];

  always_comb begin
    gset = '0;
    gset[0]      = ld_mlo;
    gset[1]      = ld_mhi;
    gset[2]      = ld_inc;
    gset[S_CTRL] = ld_ctl;
  end
  assign gclr = (wr_en && (wr_addr == A_GSTAT)) ? wr_data : '0;
  assign cset = {ld_chi, ld_clo};
  assign cclr = (wr_en && (wr_addr == A_CSTAT)) ? wr_data[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      cmp   <= '0;
      inc   <= '0;
      ctrl  <= '0;
      gstat <= '0;
      cstat <= '0;
      pend  <= 1'b0;
      ie    <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      cmp   <= cmp_nxt;
      if (ld_inc) inc <= ap_d;
      if (ld_ctl) ctrl <= ap_d & CTRL_MASK;
      gstat <= (gstat & ~gclr) | gset;
      cstat <= (cstat & ~cclr) | cset;
      if (match) pend <= 1'b1;
      else if (pend_clr) pend <= 1'b0;
      if (wr_en && (wr_addr == A_IEN)) ie <= wr_data[0];
    end
  end

  always_comb begin
    case (rd_addr)
      A_CNT_LO: rd_data = cnt[DW-1:0];
      A_CNT_HI: rd_data = cnt[CW-1:DW];
      A_CSTAT:  rd_data = {{(DW-2){1'b0}}, cstat};
      A_CMP_LO: rd_data = cmp[DW-1:0];
      A_CMP_HI: rd_data = cmp[CW-1:DW];
      A_INC:    rd_data = inc;
      A_CTRL:   rd_data = ctrl;
      A_ISTAT:  rd_data = {{(DW-1){1'b0}}, pend};
      A_IEN:    rd_data = {{(DW-1){1'b0}}, ie};
      A_GSTAT:  rd_data = gstat;
      default:  rd_data = '0;
    endcase
  end

  assign irq = pend && ie;
endmodule

// File: rtl/gcount_cmp_chk.sv
module gcount_cmp_chk #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            cnt_ld,
  input logic [2*DW-1:0] cnt,
  input logic [2*DW-1:0] cmp,
  input logic [DW-1:0]   inc,
  input logic            match,
  input logic            auto_inc,
  input logic            cmp_ld,
  input logic            pend,
  input logic            ap_v,
  input logic [AW-1:0]   ap_a,
  input logic            gstat0
);
  localparam logic [AW-1:0] A_CMP_LO = AW'('h200);

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_ld) |=> (cnt == $past(cnt)));

  // R2
  step_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_ld) |=> (cnt == $past(cnt) + 1));

  // R7
  match_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> pend);

  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && auto_inc && !cmp_ld) |=> (cmp == $past(cmp) + {{DW{1'b0}}, $past(inc)}));

  // R5
  status_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gstat0) |-> $past(ap_v && (ap_a == A_CMP_LO)));
endmodule

bind gcount_cmp gcount_cmp_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cnt_ld(cnt_ld), .cnt(cnt), .cmp(cmp),
  .inc(inc), .match(match), .auto_inc(auto_inc), .cmp_ld(cmp_ld), .pend(pend),
  .ap_v(ap_v), .ap_a(ap_a), .gstat0(gstat[0])
);

// File: tb/tb_gcount_cmp.sv
module tb_gcount_cmp;
  localparam int LAT = 3;
  localparam logic [11:0] CNT_LO = 12'h100, CNT_HI = 12'h104, CSTAT = 12'h110,
                          CMP_LO = 12'h200, CMP_HI = 12'h204, INC = 12'h208,
                          CTRL = 12'h240, ISTAT = 12'h244, IEN = 12'h248, GSTAT = 12'h24C;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  gcount_cmp dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input int lim, output bit seen);
    seen = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1; break; end
    end
  endtask

  task automatic t_reset();
    logic [11:0] al [10] = '{CNT_LO, CNT_HI, CSTAT, CMP_LO, CMP_HI, INC, CTRL, ISTAT, IEN, GSTAT};
    logic [31:0] v;
    do_reset();
    for (int i = 0; i < 10; i++) begin
      rd(al[i], v);
      chk($sformatf("R1 reg %h zero", al[i]), v, 0);
    end
    chk("R1 irq low", irq, 0);
    idle(5);
    rd(CNT_LO, v);
    chk("R1 counter stopped", v, 0);
  endtask

  task automatic t_latency();
    logic [31:0] v;
    do_reset();
    wr(CNT_LO, 32'h1234);
    idle(LAT - 1);
    rd(CNT_LO, v);  chk("R4 old value one edge early", v, 0);
    rd(CSTAT, v);   chk("R5 status not yet set", v, 0);
    idle(1);
    rd(CNT_LO, v);  chk("R4 counter low lands", v, 32'h1234);
    rd(CSTAT, v);   chk("R5 counter low status", v, 1);
    wr(CNT_HI, 32'h55);
    idle(LAT);
    rd(CNT_HI, v);  chk("R4 counter high lands", v, 32'h55);
    rd(CSTAT, v);   chk("R5 counter high status", v, 3);
    wr(CSTAT, 0);
    rd(CSTAT, v);   chk("R6 zero write keeps status", v, 3);
    wr(CSTAT, 1);
    rd(CSTAT, v);   chk("R6 clear bit 0", v, 2);
    wr(CSTAT, 2);
    rd(CSTAT, v);   chk("R6 clear bit 1", v, 0);
  endtask

  task automatic t_gstat();
    logic [31:0] v;
    do_reset();
    wr(CMP_LO, 5); wr(CMP_HI, 6); wr(INC, 7); wr(CTRL, 2);
    idle(LAT);
    rd(GSTAT, v);   chk("R5 global status bits", v, 32'h10007);
    rd(CMP_LO, v);  chk("R4 compare low", v, 5);
    rd(CMP_HI, v);  chk("R4 compare high", v, 6);
    rd(INC, v);     chk("R4 increment", v, 7);
    rd(CTRL, v);    chk("R4 control", v, 2);
    wr(GSTAT, 32'h10000);
    rd(GSTAT, v);   chk("R6 clear control status only", v, 7);
    wr(GSTAT, 32'h7);
    rd(GSTAT, v);   chk("R6 clear remaining", v, 0);
  endtask

  task automatic t_run();
    logic [31:0] a, b;
    do_reset();
    wr(CTRL, 32'h100);
    idle(LAT);
    rd(CNT_LO, a);  chk("R2 count at start", a, 0);
    idle(7);
    rd(CNT_LO, b);  chk("R2 seven cycles", b, 7);
    wr(CTRL, 0);
    idle(LAT);
    rd(CNT_LO, a);
    idle(5);
    rd(CNT_LO, b);  chk("R2 holds when stopped", b, a);
  endtask

  task automatic t_coherent_read();
    logic [31:0] hi, lo, hi2;
    int tries;
    do_reset();
    wr(CNT_LO, 32'hFFFF_FFFE);
    wr(CTRL, 32'h100);
    idle(LAT);
    tries = 0;
    rd(CNT_HI, hi);
    for (int i = 0; i < 5; i++) begin
      tries++;
      idle(1); rd(CNT_LO, lo);
      idle(1); rd(CNT_HI, hi2);
      if (hi2 == hi) break;
      hi = hi2;
    end
    chk("R3 coherent value after carry", {hi, lo}, 64'h1_0000_0001);
    chk("R3 retry taken once", tries, 2);
  endtask

  task automatic t_wide_match();
    logic [31:0] v;
    bit seen;
    do_reset();
    wr(CMP_LO, 3); wr(CMP_HI, 1); wr(IEN, 1); wr(CTRL, 32'h101);
    idle(30);
    chk("R7 low half alone no event", irq, 0);
    rd(ISTAT, v); chk("R7 low half alone not pending", v, 0);
    do_reset();
    wr(CMP_LO, 2); wr(CMP_HI, 1); wr(IEN, 1); wr(CNT_LO, 32'hFFFF_FFFD); wr(CTRL, 32'h101);
    wait_irq(40, seen);
    chk("R7 match after carry fires", seen, 1);
    rd(CNT_LO, v); chk("R3 low after carry", v, 3);
    rd(CNT_HI, v); chk("R3 high after carry", v, 1);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    bit seen;
    do_reset();
    wr(CMP_LO, 20); wr(IEN, 1); wr(CTRL, 32'h101);
    wait_irq(60, seen);
    chk("R7 one-shot fires", seen, 1);
    rd(CNT_LO, v); chk("R7 pending the edge after match", v, 21);
    rd(CMP_LO, v); chk("R8 compare unchanged without auto", v, 20);
    rd(ISTAT, v);  chk("R7 pending flag", v, 1);
    wr(ISTAT, 1);
    chk("R10 irq drops after clear", irq, 0);
    rd(ISTAT, v);  chk("R10 pending cleared", v, 0);
    idle(40);
    chk("R8 single event only", irq, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    bit seen;
    do_reset();
    wr(CMP_LO, 20); wr(INC, 10); wr(IEN, 1); wr(CTRL, 32'h103);
    wait_irq(60, seen);
    chk("R8 first periodic event", seen, 1);
    rd(CNT_LO, v); chk("R8 first event count", v, 21);
    rd(CMP_LO, v); chk("R8 rearmed compare", v, 30);
    wr(ISTAT, 1);
    chk("R10 cleared between events", irq, 0);
    wait_irq(40, seen);
    chk("R8 second periodic event", seen, 1);
    rd(CNT_LO, v); chk("R8 second event count", v, 31);
    rd(CMP_LO, v); chk("R8 rearmed again", v, 40);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    do_reset();
    wr(CMP_LO, 5); wr(IEN, 1); wr(CTRL, 32'h100);
    idle(30);
    chk("R7 disabled comparator no irq", irq, 0);
    rd(ISTAT, v); chk("R7 disabled comparator not pending", v, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    do_reset();
    wr(CMP_LO, 5); wr(CTRL, 32'h101);
    idle(30);
    chk("R9 masked irq low", irq, 0);
    rd(ISTAT, v); chk("R9 pending while masked", v, 1);
    wr(IEN, 1);
    chk("R9 enable raises irq", irq, 1);
    wr(IEN, 0);
    chk("R9 disable lowers irq", irq, 0);
    rd(ISTAT, v); chk("R9 pending kept", v, 1);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_gstat();
    t_run();
    t_coherent_read();
    t_wide_match();
    t_oneshot();
    t_periodic();
    t_disabled();
    t_mask();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule